// File: doc/BRIEF.md
# Glitch-Free Counter PWM

This block produces a single pulse-width-modulated output from an up-counter, a pulse-width limit and a period value. A software-owned run bit lets the counter advance. The counter climbs from zero to the period value and clears on the following clock, so one PWM cycle lasts period+1 clocks. The output is high while the count is below the limit.

The output comes from a flip-flop that stores the result of the count-below-limit compare. The pin therefore never shows decode glitches, but it trails the compare by one clock. The counter's next action comes from a two-bit action index. The upper bit is the run bit and the lower bit is the count-equals-period flag.

The limit and period registers load through simple write strobes. A new value is used from the clock after the write.

Top module: `glitchless_pwm`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `pwm` is low and the counter is zero. Both registers reset to zero.
- R2: When `runEn` is 1 and the counter differs from the period register, the counter increments by one on each clock. It wraps from 2^W-1 to 0, which happens when the period is written below the current count.
- R3: When `runEn` is 1 and the counter equals the period register, the counter clears to zero on the next clock. The action index {runEn, count==period} selects the action: 00 and 01 hold, 10 increments, 11 clears.
- R4: While enabled, `pwm` in cycle t+1 equals (count < limit) as evaluated in cycle t, so the output lags the compare by exactly one clock.
- R5: In steady running with 0 < limit <= period, every window of period+1 clocks holds exactly `limit` high cycles and one rising edge of `pwm`.
- R6: With limit = 0, `pwm` stays low while running.
- R7: With limit > period, `pwm` stays high while running.
- R8: While `runEn` is 0, neither the counter nor `pwm` changes, even when either register is written.
- R9: A write strobe loads its data on the clock edge. The new value takes part in the compare and period match from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Control bit: 1 lets the counter run |
| limitWe | input | 1 | Write strobe for the pulse-width limit |
| limitData | input | W | Limit value to load |
| periodWe | input | 1 | Write strobe for the period |
| periodData | input | W | Period value to load |
| pwm | output | 1 | Registered PWM output |

## Verification
The bench measures the high time and the number of rising edges over whole periods for limits of zero, one, mid-range, equal to the period, period+1 and above the period. A design that compared with <= or cleared one count late would show the wrong high count or a stretched period. A design that failed to force the output to the rails at the limit extremes would let a pulse through. The run bit is dropped in the middle of a period while registers are being written. A design that kept the output register loading would move `pwm` while the counter is frozen. Random writes put the period below the live count to check that the counter wraps through the top of its range rather than stalling.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Counter action selected by the {run, atPeriod} index
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_INCR  = 2'd1,
    ACT_CLEAR = 2'd2
  } cntAct_e;

  // Strobes handed from control to the datapath
  typedef struct packed {
    logic cntIncr;
    logic cntClear;
    logic outLoad;
  } pwmStrobes_t;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic        runEn,
  input  logic        atPeriod,
  output cntAct_e     action,
  output pwmStrobes_t strobes
);

  logic [1:0] actIdx;

  assign actIdx = {runEn, atPeriod};

  always_comb begin
    unique case (actIdx)
      2'b10:   action = ACT_INCR;
      2'b11:   action = ACT_CLEAR;
      default: action = ACT_HOLD;
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.cntIncr  = (action == ACT_INCR);
    strobes.cntClear = (action == ACT_CLEAR);
    strobes.outLoad  = runEn;
  end

endmodule

// File: rtl/pwm_dpath.sv
module pwm_dpath
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pwmStrobes_t  strobes,
  input  logic         limitWe,
  input  logic [W-1:0] limitData,
  input  logic         periodWe,
  input  logic [W-1:0] periodData,
  output logic         atPeriod,
  output logic [W-1:0] cntQ,
  output logic [W-1:0] limitQ,
  output logic [W-1:0] periodQ,
  output logic         pwmQ
);

  localparam logic [W-1:0] ONE = W'(1);

  logic belowLimit;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limitQ  <= '0;
      periodQ <= '0;
    end else begin
      if (limitWe)  limitQ  <= limitData;
      if (periodWe) periodQ <= periodData;
    end
  end

  // Counter: wraps naturally at the top of its range
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (strobes.cntClear) begin
      cntQ <= '0;
    end else if (strobes.cntIncr) begin
      cntQ <= cntQ + ONE;
    end
  end

  // Compare flags work from register values only
  assign atPeriod   = (cntQ == periodQ);
  assign belowLimit = (cntQ < limitQ);

  // Registered output removes decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwmQ <= 1'b0;
    end else if (strobes.outLoad) begin
      pwmQ <= belowLimit;
    end
  end

endmodule

// File: rtl/glitchless_pwm.sv
module glitchless_pwm
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         runEn,
  input  logic         limitWe,
  input  logic [W-1:0] limitData,
  input  logic         periodWe,
  input  logic [W-1:0] periodData,
  output logic         pwm
);

  pwmStrobes_t  strobes;
  cntAct_e      action;
  logic         atPeriod;
  logic [W-1:0] cntQ;
  logic [W-1:0] limitQ;
  logic [W-1:0] periodQ;

  pwm_ctrl u_ctrl (
    .runEn    (runEn),
    .atPeriod (atPeriod),
    .action   (action),
    .strobes  (strobes)
  );

  pwm_dpath #(.W(W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .limitWe    (limitWe),
    .limitData  (limitData),
    .periodWe   (periodWe),
    .periodData (periodData),
    .atPeriod   (atPeriod),
    .cntQ       (cntQ),
    .limitQ     (limitQ),
    .periodQ    (periodQ),
    .pwmQ       (pwm)
  );

endmodule

// File: rtl/glitchless_pwm_chk.sv
module glitchless_pwm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         runEn,
  input logic         pwm,
  input logic [W-1:0] cnt,
  input logic [W-1:0] limitQ,
  input logic [W-1:0] periodQ
);

  // R1
  reset_state_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!pwm && cnt == '0));

  // R2
  cnt_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runEn && cnt != periodQ) |=> cnt == W'($past(cnt) + 1'b1));

  // R3
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runEn && cnt == periodQ) |=> cnt == '0);

  // R4
  out_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    runEn |=> pwm == ($past(cnt) < $past(limitQ)));

  // R6
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runEn && limitQ == '0) |=> !pwm);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> ($stable(cnt) && $stable(pwm)));

endmodule

bind glitchless_pwm glitchless_pwm_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .runEn   (runEn),
  .pwm     (pwm),
  .cnt     (cntQ),
  .limitQ  (limitQ),
  .periodQ (periodQ)
);

// File: tb/test_glitchless_pwm.sv
module test_glitchless_pwm;

  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         runEn = 1'b0;
  logic         limitWe = 1'b0;
  logic [W-1:0] limitData = '0;
  logic         periodWe = 1'b0;
  logic [W-1:0] periodData = '0;
  logic         pwm;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit modelCheck = 1'b0;
  string curReq = "R4";

  // Bench model state, built from the requirements
  int mCnt = 0, mLim = 0, mPer = 0;
  bit mPwm = 1'b0;

  always #2 clk = ~clk;

  glitchless_pwm #(.W(W)) i_glitchless_pwm (
    .clk(clk), .rst_n(rst_n), .runEn(runEn),
    .limitWe(limitWe), .limitData(limitData),
    .periodWe(periodWe), .periodData(periodData),
    .pwm(pwm)
  );

  function automatic int nextCnt(int c, int p, bit en);
    if (!en) return c;
    if (c == p) return 0;
    return (c + 1) & MAXV;
  endfunction

  function automatic int expHigh(int l, int p);
    return (l > p + 1) ? p + 1 : l;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      mCnt <= 0; mLim <= 0; mPer <= 0; mPwm <= 1'b0;
    end else begin
      mCnt <= nextCnt(mCnt, mPer, runEn);
      if (runEn) mPwm <= (mCnt < mLim);
      if (limitWe)  mLim <= int'(limitData);
      if (periodWe) mPer <= int'(periodData);
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && modelCheck) check(curReq, int'(pwm), int'(mPwm), "pwm vs model");
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeRegs(int l, int p);
    @(posedge clk); #1;
    limitWe = 1'b1; limitData = W'(l);
    periodWe = 1'b1; periodData = W'(p);
    @(posedge clk); #1;
    limitWe = 1'b0; periodWe = 1'b0;
  endtask

  task automatic measure(int l, int p, string req);
    int highs = 0, rises = 0;
    bit prev;
    writeRegs(l, p);
    runEn = 1'b1;
    tick(300);
    @(negedge clk); prev = pwm;
    for (int i = 0; i < 3 * (p + 1); i++) begin
      @(negedge clk);
      if (pwm) highs++;
      if (pwm && !prev) rises++;
      prev = pwm;
    end
    check(req, highs, 3 * expHigh(l, p), $sformatf("high cycles L=%0d P=%0d", l, p));
    if (l > 0 && l <= p)
      check("R5", rises, 3, $sformatf("rising edges L=%0d P=%0d", l, p));
  endtask

  initial begin
    tick(3);
    #1;
    check("R1", int'(pwm), 0, "pwm during reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(pwm), 0, "pwm after reset");
    modelCheck = 1'b1;

    curReq = "R5"; measure(5, 9, "R5");
    measure(1, 3, "R5");
    measure(10, 10, "R5");
    measure(128, 255, "R5");
    curReq = "R6"; measure(0, 7, "R6");
    curReq = "R7"; measure(8, 7, "R7");
    measure(200, 4, "R7");
    curReq = "R3"; measure(0, 0, "R3");

    // R8: drop run mid-period while writing registers
    begin
      bit held;
      curReq = "R8";
      writeRegs(6, 11);
      runEn = 1'b1;
      tick(40);
      runEn = 1'b0;
      tick(1);
      @(negedge clk); held = pwm;
      writeRegs(held ? 0 : 200, 3);
      tick(5);
      @(negedge clk);
      check("R8", int'(pwm), int'(held), "pwm held while idle");
      runEn = 1'b1;
      tick(20);
    end

    // R2: period written below the live count forces a wrap
    begin
      int highs = 0;
      curReq = "R2";
      writeRegs(100, 200);
      tick(250);
      writeRegs(100, 5);
      // expect a high region after wrapping back to the low counts
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (pwm) highs++;
      end
      check("R2", int'(highs > 0), 1, "output resumes after wrap");
    end

    // R9 and R4: random stimulus against the model
    curReq = "R9";
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      runEn = ($urandom_range(0, 9) != 0);
      limitWe = ($urandom_range(0, 40) == 0);
      periodWe = ($urandom_range(0, 40) == 0);
      limitData = W'($urandom_range(0, 20));
      periodData = W'($urandom_range(0, 18));
    end
    @(posedge clk); #1;
    limitWe = 1'b0; periodWe = 1'b0;
    tick(4);
    modelCheck = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule